// File: doc/BRIEF.md
# Exception Entry Controller

This block runs the entry step of the exception and interrupt path of a small 32-bit in-order core. It keeps the status word, the saved program counter, the saved status copy, the faulting-address register, the two power-management enables and the load-link reservation flag. A synchronous fault from the pipeline arrives with a cause code. The external and tick interrupts arrive as level inputs and are gated by their enable bits in the status word. One cause is chosen. On the next clock edge every architectural side effect of the entry is committed together, and a vector address is presented to the fetch unit.

The saved PC is corrected for faults in a branch delay slot and for system calls. The vector is the cause code placed at bit 8, optionally merged with a base register and a high-memory prefix. The core writes the status word, sets the reservation and writes the power-management enables through simple write strobes. An entry in the same cycle overrides these writes. A cause code outside the defined set raises an error pulse and changes nothing else.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word reads 0x0001 (supervisor bit 0 set, all others clear). The saved PC, saved status, faulting address, vector, selected cause, reservation and power-management enables are all zero, and no pulse output is high.
- R2: On entry the saved PC becomes the current PC. If the delay-slot input is high, 4 is subtracted, status bit 13 (delay-slot flag) is set and the delay-flag clear pulse is raised. Otherwise bit 13 is cleared.
- R3: For cause 12 (system call), 4 is added to the saved PC after the delay-slot correction.
- R4: For cause 7 (illegal instruction), the faulting-address register is loaded with the current PC. Every other cause leaves it unchanged.
- R5: On entry the saved status register receives the status word as it was before the entry.
- R6: On entry status bits 5 (data MMU enable), 6 (instruction MMU enable), 2 (interrupt enable) and 1 (tick enable) are cleared and bit 0 (supervisor) is set. All other bits are kept, apart from bit 13 as given in R2.
- R7: The vector equals cause shifted left by 8. It is ORed with the base register when the base-enable input is high, and ORed with 0xF0000000 when status bit 14 (high vectors) is set.
- R8: The tick interrupt (cause 5) is taken only if status bit 1 is set. The external interrupt (cause 8) is taken only if status bit 2 is set. When both are pending and enabled, the tick is taken.
- R9: A valid synchronous exception request wins over any interrupts pending in the same cycle.
- R10: A request with cause 0 or a cause above 14 raises the unhandled pulse for one cycle. It gives no redirect and changes no state.
- R11: Every entry clears the reservation flag and both power-management enables (doze and sleep).
- R12: The redirect and TLB-flush outputs pulse high for one cycle after each entry, with the vector and selected cause valid at that time. An entry overrides a status, reservation or power-management write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 5 | Cause code of the request |
| irq_ext_i | input | 1 | External interrupt pending |
| irq_tick_i | input | 1 | Tick timer interrupt pending |
| pc_i | input | 32 | PC of the affected instruction |
| delay_slot_i | input | 1 | Instruction sits in a delay slot |
| vbase_i | input | 32 | Vector base register |
| vbase_en_i | input | 1 | Configuration: use vector base |
| sr_we_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 16 | Status word write data |
| resv_set_i | input | 1 | Set the load-link reservation |
| pm_we_i | input | 1 | Power-management enables write strobe |
| pm_wdata_i | input | 2 | Bit 1 sleep, bit 0 doze |
| redirect_o | output | 1 | Fetch redirect pulse |
| vector_o | output | 32 | Vector address of the last entry |
| taken_cause_o | output | 5 | Cause of the last entry |
| unhandled_o | output | 1 | Undefined-cause pulse |
| tlb_flush_o | output | 1 | TLB flush pulse |
| dflag_clr_o | output | 1 | Clear the pipeline delay flag |
| epc_o | output | 32 | Saved PC |
| esr_o | output | 16 | Saved status word |
| eear_o | output | 32 | Faulting address |
| sr_o | output | 16 | Status word |
| resv_valid_o | output | 1 | Reservation valid |
| pm_doze_o | output | 1 | Doze enable |
| pm_sleep_o | output | 1 | Sleep enable |

## Verification
Some properties are checked on every cycle. After each redirect the status word shows supervisor mode with both interrupt enables and both MMU enables clear. The reservation is clear, and the saved status matches the previous status word. An interrupt cause is only reported when its enable was set, and an unhandled pulse never occurs with a redirect. Only the bench scenarios can show the following: the exact saved-PC arithmetic for delay slots and system calls, the vector composition with and without base and prefix, and the priority between simultaneous requests. They also show that an undefined cause leaves every register untouched, and that an entry overrides a write in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;
  localparam int SR_EPH = 14;

  localparam int CAUSE_TICK    = 5;
  localparam int CAUSE_ILLEGAL = 7;
  localparam int CAUSE_EXT     = 8;
  localparam int CAUSE_SYSCALL = 12;
  localparam int CAUSE_MIN     = 1;
  localparam int CAUSE_MAX     = 14;

  localparam int VEC_SHIFT     = 8;
  localparam int PC_STEP       = 4;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int CAUSE_W = 5
) (
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               irq_ext,
  input  logic               irq_tick,
  input  logic               ie,
  input  logic               te,
  output logic               take,
  output logic               unhandled,
  output logic [CAUSE_W-1:0] cause_sel
);
  logic cause_ok;
  assign cause_ok = (exc_cause >= CAUSE_W'(CAUSE_MIN)) &&
                    (exc_cause <= CAUSE_W'(CAUSE_MAX));

  always_comb begin
    take      = 1'b0;
    unhandled = 1'b0;
    cause_sel = '0;
    if (exc_req) begin
      take      = cause_ok;
      unhandled = !cause_ok;
      cause_sel = exc_cause;
    end else if (irq_tick && te) begin
      take      = 1'b1;
      cause_sel = CAUSE_W'(CAUSE_TICK);
    end else if (irq_ext && ie) begin
      take      = 1'b1;
      cause_sel = CAUSE_W'(CAUSE_EXT);
    end
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc import exc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic            in_delay,
  input  logic            is_syscall,
  output logic [XLEN-1:0] epc
);
  logic [XLEN-1:0] ds_adj;
  always_comb begin
    ds_adj = in_delay ? (pc - XLEN'(PC_STEP)) : pc;
    epc    = is_syscall ? (ds_adj + XLEN'(PC_STEP)) : ds_adj;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen import exc_pkg::*; #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    vbase,
  input  logic               vbase_en,
  input  logic               high_vec,
  output logic [XLEN-1:0]    vector
);
  localparam logic [XLEN-1:0] HIGH_PREFIX = {4'hF, {(XLEN-4){1'b0}}};
  logic [XLEN-1:0] base_vec;
  always_comb begin
    base_vec = XLEN'(cause) << VEC_SHIFT;
    vector   = base_vec | (vbase_en ? vbase : '0) | (high_vec ? HIGH_PREFIX : '0);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl import exc_pkg::*; #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter int SR_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_ext_i,
  input  logic               irq_tick_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               delay_slot_i,
  input  logic [XLEN-1:0]    vbase_i,
  input  logic               vbase_en_i,
  input  logic               sr_we_i,
  input  logic [SR_W-1:0]    sr_wdata_i,
  input  logic               resv_set_i,
  input  logic               pm_we_i,
  input  logic [1:0]         pm_wdata_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    vector_o,
  output logic [CAUSE_W-1:0] taken_cause_o,
  output logic               unhandled_o,
  output logic               tlb_flush_o,
  output logic               dflag_clr_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [SR_W-1:0]    esr_o,
  output logic [XLEN-1:0]    eear_o,
  output logic [SR_W-1:0]    sr_o,
  output logic               resv_valid_o,
  output logic               pm_doze_o,
  output logic               pm_sleep_o
);
  localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << SR_SM;
  localparam logic [SR_W-1:0] SR_CLR_MASK =
    (SR_W'(1) << SR_DME) | (SR_W'(1) << SR_IME) |
    (SR_W'(1) << SR_IEE) | (SR_W'(1) << SR_TEE) | (SR_W'(1) << SR_DSX);

  logic               take, unh;
  logic [CAUSE_W-1:0] cause_sel;
  logic [XLEN-1:0]    epc_new, vec_new;

  logic               redirect_q, redirect_d, flush_q, flush_d;
  logic               dclr_q, dclr_d, unh_q, unh_d;
  logic [XLEN-1:0]    vec_q, vec_d, epc_q, epc_d, eear_q, eear_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [SR_W-1:0]    sr_q, sr_d, esr_q, esr_d;
  logic               resv_q, resv_d, doze_q, doze_d, sleep_q, sleep_d;

  exc_arbiter #(.CAUSE_W(CAUSE_W)) u_arb (
    .exc_req   (exc_req_i),
    .exc_cause (exc_cause_i),
    .irq_ext   (irq_ext_i),
    .irq_tick  (irq_tick_i),
    .ie        (sr_q[SR_IEE]),
    .te        (sr_q[SR_TEE]),
    .take      (take),
    .unhandled (unh),
    .cause_sel (cause_sel)
  );

  exc_epc_calc #(.XLEN(XLEN)) u_epc (
    .pc         (pc_i),
    .in_delay   (delay_slot_i),
    .is_syscall (cause_sel == CAUSE_W'(CAUSE_SYSCALL)),
    .epc        (epc_new)
  );

  exc_vector_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .cause    (cause_sel),
    .vbase    (vbase_i),
    .vbase_en (vbase_en_i),
    .high_vec (sr_q[SR_EPH]),
    .vector   (vec_new)
  );

  always_comb begin
    redirect_d = 1'b0;
    flush_d    = 1'b0;
    dclr_d     = 1'b0;
    unh_d      = unh;
    vec_d      = vec_q;
    cause_d    = cause_q;
    epc_d      = epc_q;
    eear_d     = eear_q;
    esr_d      = esr_q;
    sr_d       = sr_we_i ? sr_wdata_i : sr_q;
    resv_d     = resv_q | resv_set_i;
    doze_d     = pm_we_i ? pm_wdata_i[0] : doze_q;
    sleep_d    = pm_we_i ? pm_wdata_i[1] : sleep_q;
    if (take) begin
      redirect_d = 1'b1;
      flush_d    = 1'b1;
      dclr_d     = delay_slot_i;
      vec_d      = vec_new;
      cause_d    = cause_sel;
      epc_d      = epc_new;
      if (cause_sel == CAUSE_W'(CAUSE_ILLEGAL)) eear_d = pc_i;
      esr_d      = sr_q;
      sr_d       = (sr_q & ~SR_CLR_MASK) | SR_RESET |
                   (delay_slot_i ? (SR_W'(1) << SR_DSX) : '0);
      resv_d     = 1'b0;
      doze_d     = 1'b0;
      sleep_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      flush_q    <= 1'b0;
      dclr_q     <= 1'b0;
      unh_q      <= 1'b0;
      vec_q      <= '0;
      cause_q    <= '0;
      epc_q      <= '0;
      eear_q     <= '0;
      esr_q      <= '0;
      sr_q       <= SR_RESET;
      resv_q     <= 1'b0;
      doze_q     <= 1'b0;
      sleep_q    <= 1'b0;
    end else begin
      redirect_q <= redirect_d;
      flush_q    <= flush_d;
      dclr_q     <= dclr_d;
      unh_q      <= unh_d;
      vec_q      <= vec_d;
      cause_q    <= cause_d;
      epc_q      <= epc_d;
      eear_q     <= eear_d;
      esr_q      <= esr_d;
      sr_q       <= sr_d;
      resv_q     <= resv_d;
      doze_q     <= doze_d;
      sleep_q    <= sleep_d;
    end
  end

  assign redirect_o    = redirect_q;
  assign tlb_flush_o   = flush_q;
  assign dflag_clr_o   = dclr_q;
  assign unhandled_o   = unh_q;
  assign vector_o      = vec_q;
  assign taken_cause_o = cause_q;
  assign epc_o         = epc_q;
  assign eear_o        = eear_q;
  assign esr_o         = esr_q;
  assign sr_o          = sr_q;
  assign resv_valid_o  = resv_q;
  assign pm_doze_o     = doze_q;
  assign pm_sleep_o    = sleep_q;

  assert_sup_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (sr_o[SR_SM] && !sr_o[SR_IEE] && !sr_o[SR_TEE] &&
                    !sr_o[SR_DME] && !sr_o[SR_IME]));
  assert_esr_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (esr_o == $past(sr_o)));
  assert_resv_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (!resv_valid_o && !pm_doze_o && !pm_sleep_o));
  assert_unh_no_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled_o |-> !redirect_o);
  assert_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && take && cause_sel == CAUSE_W'(CAUSE_TICK)) |-> sr_o[SR_TEE]);
  assert_ext_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && take && cause_sel == CAUSE_W'(CAUSE_EXT)) |->
      (sr_o[SR_IEE] && !(irq_tick_i && sr_o[SR_TEE])));
  assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> (redirect_o ? (taken_cause_o == $past(exc_cause_i)) : unhandled_o));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        exc_req, irq_ext, irq_tick, ds, vben, srwe, llset, pmwe;
  logic [4:0]  cause;
  logic [31:0] pc, vbase;
  logic [15:0] srwd;
  logic [1:0]  pmwd;

  logic        redirect, unh, flush, dclr, resv, doze, sleep;
  logic [31:0] vec, epc, eear;
  logic [4:0]  tcause;
  logic [15:0] sr, esr;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .irq_ext_i(irq_ext), .irq_tick_i(irq_tick), .pc_i(pc), .delay_slot_i(ds),
    .vbase_i(vbase), .vbase_en_i(vben), .sr_we_i(srwe), .sr_wdata_i(srwd),
    .resv_set_i(llset), .pm_we_i(pmwe), .pm_wdata_i(pmwd),
    .redirect_o(redirect), .vector_o(vec), .taken_cause_o(tcause),
    .unhandled_o(unh), .tlb_flush_o(flush), .dflag_clr_o(dclr),
    .epc_o(epc), .esr_o(esr), .eear_o(eear), .sr_o(sr),
    .resv_valid_o(resv), .pm_doze_o(doze), .pm_sleep_o(sleep)
  );

  typedef struct {
    int          due;
    string       tag;
    logic        redirect, unh, flush, dclr, resv, doze, sleep;
    logic [31:0] vec, epc, eear;
    logic [4:0]  tcause;
    logic [15:0] sr, esr;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  exp_t m;

  task automatic cmp(input string tag, input string f, input logic [31:0] a, input logic [31:0] e);
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, a, e);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      cmp(e.tag, "redirect", 32'(redirect), 32'(e.redirect));
      cmp(e.tag, "flush", 32'(flush), 32'(e.flush));
      cmp(e.tag, "unhandled", 32'(unh), 32'(e.unh));
      cmp(e.tag, "dflag_clr", 32'(dclr), 32'(e.dclr));
      cmp(e.tag, "vector", vec, e.vec);
      cmp(e.tag, "cause", 32'(tcause), 32'(e.tcause));
      cmp(e.tag, "epc", epc, e.epc);
      cmp(e.tag, "eear", eear, e.eear);
      cmp(e.tag, "sr", 32'(sr), 32'(e.sr));
      cmp(e.tag, "esr", 32'(esr), 32'(e.esr));
      cmp(e.tag, "resv", 32'(resv), 32'(e.resv));
      cmp(e.tag, "doze", 32'(doze), 32'(e.doze));
      cmp(e.tag, "sleep", 32'(sleep), 32'(e.sleep));
    end
  end

  task automatic drive(input logic x_req, input logic [4:0] x_cause, input logic x_ext,
                       input logic x_tick, input logic [31:0] x_pc, input logic x_ds,
                       input logic [31:0] x_vb, input logic x_vben, input logic x_srwe,
                       input logic [15:0] x_srwd, input logic x_ll, input logic x_pmwe,
                       input logic [1:0] x_pmwd, input string tag);
    logic take, bad;
    logic [4:0] c;
    logic [31:0] e_pc;
    @(negedge clk);
    exc_req = x_req; cause = x_cause; irq_ext = x_ext; irq_tick = x_tick;
    pc = x_pc; ds = x_ds; vbase = x_vb; vben = x_vben; srwe = x_srwe;
    srwd = x_srwd; llset = x_ll; pmwe = x_pmwe; pmwd = x_pmwd;
    take = 1'b0; bad = 1'b0; c = '0;
    if (x_req) begin
      if (x_cause >= 1 && x_cause <= 14) begin take = 1'b1; c = x_cause; end
      else bad = 1'b1;
    end else if (x_tick && m.sr[1]) begin take = 1'b1; c = 5'd5; end
    else if (x_ext && m.sr[2]) begin take = 1'b1; c = 5'd8; end
    m.redirect = take; m.flush = take; m.unh = bad; m.dclr = take && x_ds;
    if (take) begin
      e_pc = x_pc - (x_ds ? 32'd4 : 32'd0) + ((c == 5'd12) ? 32'd4 : 32'd0);
      m.vec = (32'(c) << 8) | (x_vben ? x_vb : 32'd0) | (m.sr[14] ? 32'hF000_0000 : 32'd0);
      m.tcause = c;
      m.epc = e_pc;
      if (c == 5'd7) m.eear = x_pc;
      m.esr = m.sr;
      m.sr = (m.sr & ~16'h2066) | 16'h0001 | (x_ds ? 16'h2000 : 16'h0000);
      m.resv = 1'b0; m.doze = 1'b0; m.sleep = 1'b0;
    end else begin
      if (x_srwe) m.sr = x_srwd;
      if (x_ll) m.resv = 1'b1;
      if (x_pmwe) begin m.doze = x_pmwd[0]; m.sleep = x_pmwd[1]; end
    end
    m.due = cyc + 1;
    m.tag = tag;
    q.push_back(m);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr_sr(input logic [15:0] v, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    exc_req = 0; cause = 0; irq_ext = 0; irq_tick = 0; pc = 0; ds = 0;
    vbase = 0; vben = 0; srwe = 0; srwd = 0; llset = 0; pmwe = 0; pmwd = 0;
    m = '{due: 0, tag: "", redirect: 0, unh: 0, flush: 0, dclr: 0, resv: 0,
          doze: 0, sleep: 0, vec: 0, epc: 0, eear: 0, tcause: 0, sr: 16'h0001, esr: 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    // set enables, reservation and power-management bits
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0067, 1, 1, 2'b11, "R12 writes");
    // bus error, no delay slot
    drive(1, 5'd2, 0, 0, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R5 R6 R11 plain entry");
    idle("R12 pulse drops");
    // delay slot entry, alignment fault
    wr_sr(16'h0067, "R6 setup");
    drive(1, 5'd6, 0, 0, 32'h0000_2004, 1, 0, 0, 0, 0, 0, 0, 0, "R2 delay slot");
    // system call in delay slot and without
    drive(1, 5'd12, 0, 0, 32'h0000_3008, 1, 0, 0, 0, 0, 0, 0, 0, "R3 syscall in slot");
    drive(1, 5'd12, 0, 0, 32'h0000_3100, 0, 0, 0, 0, 0, 0, 0, 0, "R3 syscall");
    // illegal sets eear, then another cause keeps it
    drive(1, 5'd7, 0, 0, 32'h0000_4444, 0, 0, 0, 0, 0, 0, 0, 0, "R4 illegal");
    drive(1, 5'd11, 0, 0, 32'h0000_5555, 0, 0, 0, 0, 0, 0, 0, 0, "R4 other cause");
    // vector composition
    wr_sr(16'h4001, "R7 setup");
    drive(1, 5'd3, 0, 0, 32'h100, 0, 32'h0001_0000, 1, 0, 0, 0, 0, 0, "R7 base and prefix");
    drive(1, 5'd9, 0, 0, 32'h100, 0, 32'h0002_0000, 0, 0, 0, 0, 0, 0, "R7 prefix only");
    wr_sr(16'h0001, "R7 setup2");
    drive(1, 5'd10, 0, 0, 32'h100, 0, 32'h0003_0000, 0, 0, 0, 0, 0, 0, "R7 plain");
    // interrupts
    wr_sr(16'h0007, "R8 setup");
    drive(0, 0, 1, 1, 32'h0000_6000, 0, 0, 0, 0, 0, 0, 0, 0, "R8 tick beats ext");
    wr_sr(16'h0005, "R8 setup2");
    drive(0, 0, 1, 1, 32'h0000_6100, 0, 0, 0, 0, 0, 0, 0, 0, "R8 ext only enabled");
    drive(0, 0, 1, 1, 32'h0000_6200, 0, 0, 0, 0, 0, 0, 0, 0, "R8 both gated");
    wr_sr(16'h0003, "R8 setup3");
    drive(0, 0, 1, 0, 32'h0000_6300, 0, 0, 0, 0, 0, 0, 0, 0, "R8 ext gated");
    // sync beats interrupts
    wr_sr(16'h0007, "R9 setup");
    drive(1, 5'd14, 1, 1, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 0, 0, "R9 sync wins");
    // unhandled causes
    wr_sr(16'h0007, "R10 setup");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2'b01, "R10 setup2");
    drive(1, 5'd0, 1, 1, 32'h0000_8000, 1, 0, 0, 0, 0, 0, 0, 0, "R10 cause 0");
    drive(1, 5'd15, 0, 0, 32'h0000_8004, 0, 0, 0, 0, 0, 0, 0, 0, "R10 cause 15");
    drive(1, 5'd31, 0, 0, 32'h0000_8008, 0, 0, 0, 0, 0, 0, 0, 0, "R10 cause 31");
    // entry overrides same-cycle writes
    drive(1, 5'd13, 0, 0, 32'h0000_9000, 0, 0, 0, 1, 16'h0066, 1, 1, 2'b11, "R12 entry overrides");
    idle("R12 final");
    idle("R12 final2");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule